// File: doc/BRIEF.md
# Single-Word Stream Receiver

This block is the receiving end of a stream link. It takes one word at a time from a stream master over a TVALID/TREADY/TDATA/TLAST slave port. It passes each word to a local consumer through a plain ready/data/done interface. The consumer raises its ready input when it can take a word. The block registers that request and drives it out as TREADY, so the master is only offered acceptance when the consumer has room.

A transfer completes at any rising clock edge where TVALID and TREADY are both high. At that edge the block latches TDATA and TLAST into output registers. In the following cycle it raises a one-cycle done pulse. The latched word and end-of-packet flag stay on the outputs until the next accepted transfer. There is no queue: the outputs hold one word only. The consumer must read the word in the cycle the done pulse is high, or at the latest before the next transfer completes.

Top module: `axis_word_sink`

## Requirements
- R1: Reset is synchronous and active low. After any rising edge where rst_n is low, s_tready, usr_done, usr_last and every bit of usr_data are 0.
- R2: s_tready is registered. After each rising edge with rst_n high, it equals the value usr_rdy had at that edge, so it trails usr_rdy by one cycle.
- R3: At a rising edge where s_tvalid and s_tready are both 1, the block captures s_tdata. The captured word appears on usr_data (32 bits by default) right after that edge.
- R4: At the same handshake edge, s_tlast is captured and driven on usr_last.
- R5: usr_done is 1 for exactly the one cycle after each handshake edge, and 0 in every other cycle.
- R6: usr_data and usr_last keep their values through every edge that is not a handshake.
- R7: While s_tvalid is 0, no word is accepted even if s_tready is 1. usr_done stays 0 and usr_data/usr_last do not change.
- R8: While s_tready is 0, no word is accepted even if s_tvalid is 1. usr_done stays 0 and usr_data/usr_last do not change.
- R9: Handshakes on consecutive edges each deliver their own word, with usr_done held high across the run, one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tvalid | input | 1 | Master has a word on s_tdata |
| s_tready | output | 1 | Block accepts a word this cycle |
| s_tdata | input | DATA_W | Word from the master |
| s_tlast | input | 1 | Word ends a packet |
| usr_rdy | input | 1 | Consumer can take a word |
| usr_data | output | DATA_W | Last accepted word |
| usr_last | output | 1 | End-of-packet flag of the last accepted word |
| usr_done | output | 1 | One-cycle pulse after each accepted word |

## Verification
The bench drives every three-cycle sequence of consumer ready, TVALID and TLAST, with a fresh arithmetic data word each cycle. This covers all cases where TVALID and TREADY disagree. A design that captured on TVALID alone would change usr_data while TREADY is low. A design that captured on TREADY alone would take a stale word while TVALID is low. A design that drove TREADY combinationally would lead the reference model by one cycle.

Long bursts with both sides held high check that a done pulse that clears itself unconditionally would show a gap between consecutive words. A reset applied in the middle of traffic confirms that the data register clears as well as the flags.

// File: rtl/axis_sink_pkg.sv
// axis_sink_pkg
// Shared defaults for the single-word stream receiver.
// Assumes: consumers take the default width unless they override DATA_W.
package axis_sink_pkg;
    localparam int unsigned SINK_DATA_W = 32;
endpackage

// File: rtl/axis_sink_ready.sv
// axis_sink_ready
// Turns the consumer's ready request into the registered TREADY.
// Assumes: usr_rdy is synchronous to clk; reset is synchronous, active low.
module axis_sink_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic usr_rdy,
    output logic tready
);
    // Register the consumer request; cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tready <= 1'b0;
        end else begin
            tready <= usr_rdy;
        end
    end
endmodule

// File: rtl/axis_sink_capture.sv
// axis_sink_capture
// Latches one beat (data and last flag) on a handshake and pulses done.
// Assumes: 'take' is the qualified handshake for the current edge.
module axis_sink_capture #(
    parameter int unsigned DATA_W = axis_sink_pkg::SINK_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_done
);
    // Word register: loads on a handshake, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_last <= 1'b0;
        end else if (take) begin
            out_data <= in_data;
            out_last <= in_last;
        end
    end

    // Done flag: high for the one cycle after each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done <= 1'b0;
        end else begin
            out_done <= take;
        end
    end
endmodule

// File: rtl/axis_word_sink.sv
// axis_word_sink
// Single-word stream receiver: TREADY follows the consumer's ready with
// one register of delay; each accepted beat is latched and flagged.
// Assumes: one clock domain, synchronous active-low reset, no buffering.
module axis_word_sink #(
    parameter int unsigned DATA_W = axis_sink_pkg::SINK_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tlast,
    input  logic              usr_rdy,
    output logic [DATA_W-1:0] usr_data,
    output logic              usr_last,
    output logic              usr_done
);
    logic tready_q;
    logic hs;

    // Handshake qualification for the current edge.
    always_comb hs = s_tvalid && tready_q;

    assign s_tready = tready_q;

    axis_sink_ready u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .usr_rdy (usr_rdy),
        .tready  (tready_q)
    );

    axis_sink_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (hs),
        .in_data  (s_tdata),
        .in_last  (s_tlast),
        .out_data (usr_data),
        .out_last (usr_last),
        .out_done (usr_done)
    );
endmodule

// File: rtl/axis_word_sink_chk.sv
// axis_word_sink_chk
// Port-level protocol checks for axis_word_sink, bound to every instance.
// Assumes: all checks are sampled on the rising clock edge.
module axis_word_sink_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic [DATA_W-1:0] s_tdata,
    input logic              s_tlast,
    input logic              usr_rdy,
    input logic [DATA_W-1:0] usr_data,
    input logic              usr_last,
    input logic              usr_done
);
    // R1: reset clears the handshake and done flags
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!s_tready && !usr_done && !usr_last && usr_data == '0));

    // R2: TREADY trails usr_rdy by one cycle
    p_rdy_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s_tready == $past(usr_rdy)));

    // R3: the handshake word appears on usr_data
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(s_tvalid && s_tready)) |-> (usr_data == $past(s_tdata)));

    // R4: the handshake last flag appears on usr_last
    p_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(s_tvalid && s_tready)) |-> (usr_last == $past(s_tlast)));

    // R5: done is a pulse tied to the previous handshake
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (usr_done == $past(s_tvalid && s_tready)));

    // R6: no handshake, outputs hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(s_tvalid && s_tready)) |-> ($stable(usr_data) && $stable(usr_last)));
endmodule

bind axis_word_sink axis_word_sink_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tdata  (s_tdata),
    .s_tlast  (s_tlast),
    .usr_rdy  (usr_rdy),
    .usr_data (usr_data),
    .usr_last (usr_last),
    .usr_done (usr_done)
);

// File: tb/axis_word_sink_tb_top.sv
`timescale 1ns / 1ps
module axis_word_sink_tb_top;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tlast = 1'b0;
    logic          usr_rdy = 1'b0;
    logic [DW-1:0] usr_data;
    logic          usr_last;
    logic          usr_done;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference state
    logic          m_tready = 1'b0;
    logic [DW-1:0] m_data = '0;
    logic          m_last = 1'b0;
    logic          m_done = 1'b0;
    logic          prev_hs = 1'b0;
    logic          prev2_hs = 1'b0;
    logic          prev_tv = 1'b0;
    logic          prev_tr = 1'b0;

    always #5 clk = ~clk;

    axis_word_sink #(.DATA_W(DW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_tvalid (s_tvalid),
        .s_tready (s_tready),
        .s_tdata  (s_tdata),
        .s_tlast  (s_tlast),
        .usr_rdy  (usr_rdy),
        .usr_data (usr_data),
        .usr_last (usr_last),
        .usr_done (usr_done)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, compare at next negedge.
    task automatic step(input logic rst, input logic rdy, input logic tv,
                        input logic tl, input logic [DW-1:0] td);
        string dtag;
        string ftag;
        rst_n = rst; usr_rdy = rdy; s_tvalid = tv; s_tlast = tl; s_tdata = td;
        @(posedge clk);
        prev2_hs = prev_hs;
        prev_tv  = tv;
        prev_tr  = m_tready;
        if (!rst) begin
            m_tready = 1'b0; m_data = '0; m_last = 1'b0; m_done = 1'b0; prev_hs = 1'b0;
        end else begin
            prev_hs = tv && m_tready;
            m_done  = prev_hs;
            if (prev_hs) begin
                m_data = td; m_last = tl;
            end
            m_tready = rdy;
        end
        @(negedge clk);
        if (!rst) begin
            chk("R1 tready", DW'(s_tready), '0);
            chk("R1 done",   DW'(usr_done), '0);
            chk("R1 last",   DW'(usr_last), '0);
            chk("R1 data",   usr_data, '0);
        end else begin
            if (prev_hs)                dtag = "R3";
            else if (prev_tv && !prev_tr) dtag = "R8";
            else if (!prev_tv && prev_tr) dtag = "R7";
            else                        dtag = "R6";
            ftag = (prev_hs && prev2_hs) ? "R9" : "R5";
            chk("R2 tready", DW'(s_tready), DW'(m_tready));
            chk({dtag, " data"}, usr_data, m_data);
            chk({prev_hs ? "R4" : dtag, " last"}, DW'(usr_last), DW'(m_last));
            chk({ftag, " done"}, DW'(usr_done), DW'(m_done));
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int n);
        return DW'(n) * 32'h9E37_79B9 + 32'h0123_4567;
    endfunction

    initial begin
        int n;
        n = 0;
        @(negedge clk);
        // R1: reset with busy inputs
        step(1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
        step(1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
        // exhaustive 3-cycle sweep of (rdy, tvalid, tlast)
        for (int p = 0; p < 512; p++) begin
            for (int c = 0; c < 3; c++) begin
                step(1'b1, p[3*c], p[3*c+1], p[3*c+2], word_of(n));
                n++;
            end
        end
        // R9: long back-to-back burst
        for (int b = 0; b < 16; b++) begin
            step(1'b1, 1'b1, 1'b1, b[0], word_of(n));
            n++;
        end
        // R1: reset in the middle of traffic, then resume
        step(1'b0, 1'b1, 1'b1, 1'b1, word_of(n));
        step(1'b1, 1'b1, 1'b1, 1'b1, word_of(n + 1));
        step(1'b1, 1'b1, 1'b1, 1'b0, word_of(n + 2));
        step(1'b1, 1'b0, 1'b0, 1'b0, word_of(n + 3));
        step(1'b1, 1'b0, 1'b0, 1'b0, word_of(n + 4));
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule